// File: doc/BRIEF.md
# Accumulator Machine Register Datapath

This block holds the architectural and transfer registers of a single-address accumulator processor. There is an 8-bit memory address register, a 16-bit memory buffer, an 8-bit program counter, an 8-bit instruction register, a 16-bit operand buffer and a 16-bit accumulator. An external microsequencer drives a 14-bit control vector. Each bit of that vector enables exactly one register transfer. Several bits may be active in one cycle, and when two of them target the same register a fixed priority decides.

The instruction word has an 8-bit opcode in its upper byte and an 8-bit address or immediate in its lower byte. The datapath connects to a 256-word by 16-bit synchronous RAM. The memory address register drives the RAM address, and the memory buffer drives the write data. The datapath passes the accumulator and the operand buffer to an external ALU and takes the ALU result back. It reports the opcode and the accumulator sign to the sequencer, which uses the sign for a branch-if-non-negative decision.

Top module: `accum_regpath`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared at that edge: `ram_addr`, `ram_wdata`, `pc`, `opcode`, `alu_a` and `alu_b` all read zero. `ram_we` is held low during reset, so execution starts at address 0.
- R2: Control bit 8 loads the address register from the program counter. Control bit 3 loads it from bits 7:0 of the memory buffer. When both are set, bit 3 wins. The new value appears on `ram_addr` after the edge.
- R3: Control bit 9 increments the program counter modulo 256, so 0xFF wraps to 0x00. Control bit 4 loads it from bits 7:0 of the memory buffer. When both are set, the load wins.
- R4: Control bit 0 loads the memory buffer from `ram_rdata`. Control bit 2 loads it from the accumulator. When both are set, bit 0 wins. The buffer is visible on `ram_wdata`.
- R5: `ram_we` equals control bit 1 in the same cycle, with no register delay. The data written is the registered memory buffer.
- R6: Control bit 5 loads `opcode` from bits 15:8 of the memory buffer. The low byte does not affect it.
- R7: Control bit 6 copies the memory buffer into the operand buffer, which is seen on `alu_b`.
- R8: Control bit 12 loads the accumulator from `alu_result`. Control bit 13 clears it. When both are set, the clear wins. The accumulator is seen on `alu_a`.
- R9: `acc_neg` equals bit 15 of the accumulator, so a branch-if-non-negative is taken when `acc_neg` is 0.
- R10: A register with no enabled transfer keeps its value. Control bits 7, 10 and 11 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl | input | 14 | One-hot-per-transfer control vector from the sequencer |
| ram_rdata | input | 16 | RAM read data |
| alu_result | input | 16 | Result from the external ALU |
| ram_addr | output | 8 | RAM address (memory address register) |
| ram_wdata | output | 16 | RAM write data (memory buffer) |
| ram_we | output | 1 | RAM write strobe |
| pc | output | 8 | Program counter |
| opcode | output | 8 | Instruction register |
| alu_a | output | 16 | Accumulator to the ALU |
| alu_b | output | 16 | Operand buffer to the ALU |
| acc_neg | output | 1 | Accumulator sign bit |

## Verification
Every register is driven straight onto a port, so a wrong internal value shows up at the ports one edge after the transfer that produced it. A register that takes the wrong source, or that loses a priority contest it should win, differs from the scoreboard model on the very next sampled vector. A wrong value can also propagate: a corrupted memory buffer later reaches the address register, the program counter, the instruction register and the operand buffer through their own transfers. Long pseudo-random control runs let such errors spread, and they also exercise the overlapping transfers that directed vectors miss.

// File: rtl/accum_pkg.sv
package accum_pkg;

    localparam int CTL_W = 14;

    // Control vector bit positions (decoded by the external sequencer)
    localparam int CB_MBR_FROM_MEM = 0;
    localparam int CB_MEM_WRITE    = 1;
    localparam int CB_MBR_FROM_ACC = 2;
    localparam int CB_MAR_FROM_MBR = 3;
    localparam int CB_PC_FROM_MBR  = 4;
    localparam int CB_IR_FROM_MBR  = 5;
    localparam int CB_BR_FROM_MBR  = 6;
    localparam int CB_MAR_FROM_PC  = 8;
    localparam int CB_PC_STEP      = 9;
    localparam int CB_ACC_FROM_ALU = 12;
    localparam int CB_ACC_ZERO     = 13;

    typedef struct packed {
        logic mbr_mem;
        logic mem_wr;
        logic mbr_acc;
        logic mar_mbr;
        logic pc_mbr;
        logic ir_mbr;
        logic br_mbr;
        logic mar_pc;
        logic pc_step;
        logic acc_alu;
        logic acc_zero;
    } xfer_t;

    typedef enum logic [1:0] {MAR_KEEP, MAR_PC, MAR_OPND} mar_src_e;
    typedef enum logic [1:0] {PC_KEEP, PC_STEP, PC_JUMP} pc_act_e;
    typedef enum logic [1:0] {MBR_KEEP, MBR_MEM, MBR_ACC} mbr_src_e;
    typedef enum logic [1:0] {ACC_KEEP, ACC_LOAD, ACC_ZERO} acc_act_e;

    function automatic xfer_t decode_xfer(input logic [CTL_W-1:0] c);
        xfer_t x;
        x.mbr_mem  = c[CB_MBR_FROM_MEM];
        x.mem_wr   = c[CB_MEM_WRITE];
        x.mbr_acc  = c[CB_MBR_FROM_ACC];
        x.mar_mbr  = c[CB_MAR_FROM_MBR];
        x.pc_mbr   = c[CB_PC_FROM_MBR];
        x.ir_mbr   = c[CB_IR_FROM_MBR];
        x.br_mbr   = c[CB_BR_FROM_MBR];
        x.mar_pc   = c[CB_MAR_FROM_PC];
        x.pc_step  = c[CB_PC_STEP];
        x.acc_alu  = c[CB_ACC_FROM_ALU];
        x.acc_zero = c[CB_ACC_ZERO];
        return x;
    endfunction

    function automatic mar_src_e pick_mar(input xfer_t x);
        if (x.mar_mbr)     return MAR_OPND;
        else if (x.mar_pc) return MAR_PC;
        else               return MAR_KEEP;
    endfunction

    function automatic pc_act_e pick_pc(input xfer_t x);
        if (x.pc_mbr)       return PC_JUMP;
        else if (x.pc_step) return PC_STEP;
        else                return PC_KEEP;
    endfunction

    function automatic mbr_src_e pick_mbr(input xfer_t x);
        if (x.mbr_mem)      return MBR_MEM;
        else if (x.mbr_acc) return MBR_ACC;
        else                return MBR_KEEP;
    endfunction

    function automatic acc_act_e pick_acc(input xfer_t x);
        if (x.acc_zero)     return ACC_ZERO;
        else if (x.acc_alu) return ACC_LOAD;
        else                return ACC_KEEP;
    endfunction

endpackage

// File: rtl/accum_addr_unit.sv
module accum_addr_unit
    import accum_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_t             xf,
    input  logic [ADDR_W-1:0] opnd,
    output logic [ADDR_W-1:0] mar_q,
    output logic [ADDR_W-1:0] pc_q
);

    mar_src_e mar_sel;
    pc_act_e  pc_sel;
    logic [ADDR_W-1:0] pc_inc;

    always_comb begin
        mar_sel = pick_mar(xf);
        pc_sel  = pick_pc(xf);
        pc_inc  = pc_q + ADDR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q <= '0;
        end else begin
            case (mar_sel)
                MAR_PC:   mar_q <= pc_q;
                MAR_OPND: mar_q <= opnd;
                default:  mar_q <= mar_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            case (pc_sel)
                PC_STEP: pc_q <= pc_inc;
                PC_JUMP: pc_q <= opnd;
                default: pc_q <= pc_q;
            endcase
        end
    end

endmodule

// File: rtl/accum_buf_unit.sv
module accum_buf_unit
    import accum_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int OPC_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_t             xf,
    input  logic [DATA_W-1:0] mem_rd,
    input  logic [DATA_W-1:0] acc_q,
    output logic [DATA_W-1:0] mbr_q,
    output logic [OPC_W-1:0]  ir_q
);

    mbr_src_e mbr_sel;

    always_comb mbr_sel = pick_mbr(xf);

    always_ff @(posedge clk) begin
        if (rst) begin
            mbr_q <= '0;
        end else begin
            case (mbr_sel)
                MBR_MEM: mbr_q <= mem_rd;
                MBR_ACC: mbr_q <= acc_q;
                default: mbr_q <= mbr_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            ir_q <= '0;
        else if (xf.ir_mbr) ir_q <= mbr_q[DATA_W-1 -: OPC_W];
    end

endmodule

// File: rtl/accum_oper_unit.sv
module accum_oper_unit
    import accum_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  xfer_t             xf,
    input  logic [DATA_W-1:0] mbr_q,
    input  logic [DATA_W-1:0] alu_y,
    output logic [DATA_W-1:0] br_q,
    output logic [DATA_W-1:0] acc_q
);

    acc_act_e acc_sel;

    always_comb acc_sel = pick_acc(xf);

    always_ff @(posedge clk) begin
        if (rst)            br_q <= '0;
        else if (xf.br_mbr) br_q <= mbr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            case (acc_sel)
                ACC_ZERO: acc_q <= '0;
                ACC_LOAD: acc_q <= alu_y;
                default:  acc_q <= acc_q;
            endcase
        end
    end

endmodule

// File: rtl/accum_regpath.sv
module accum_regpath
    import accum_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTL_W-1:0]  ctl,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] alu_result,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-ADDR_W-1:0] opcode,
    output logic [DATA_W-1:0] alu_a,
    output logic [DATA_W-1:0] alu_b,
    output logic              acc_neg
);

    localparam int OPC_W = DATA_W - ADDR_W;

    xfer_t xf;
    logic  ctl_unused;
    logic [DATA_W-1:0] mbr_q, acc_q, br_q;
    logic [ADDR_W-1:0] mar_q, pc_q;
    logic [OPC_W-1:0]  ir_q;

    // bits that drive the ALU operand muxes and the multiplier live outside this block
    assign ctl_unused = ^{ctl[7], ctl[10], ctl[11]};

    always_comb xf = decode_xfer(ctl);

    accum_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst   (rst),
        .xf    (xf),
        .opnd  (mbr_q[ADDR_W-1:0]),
        .mar_q (mar_q),
        .pc_q  (pc_q)
    );

    accum_buf_unit #(.DATA_W(DATA_W), .OPC_W(OPC_W)) u_buf (
        .clk    (clk),
        .rst    (rst),
        .xf     (xf),
        .mem_rd (ram_rdata),
        .acc_q  (acc_q),
        .mbr_q  (mbr_q),
        .ir_q   (ir_q)
    );

    accum_oper_unit #(.DATA_W(DATA_W)) u_oper (
        .clk   (clk),
        .rst   (rst),
        .xf    (xf),
        .mbr_q (mbr_q),
        .alu_y (alu_result),
        .br_q  (br_q),
        .acc_q (acc_q)
    );

    always_comb begin
        ram_addr  = mar_q;
        ram_wdata = mbr_q;
        ram_we    = xf.mem_wr & ~rst;
        pc        = pc_q;
        opcode    = ir_q;
        alu_a     = acc_q;
        alu_b     = br_q;
        acc_neg   = acc_q[DATA_W-1];
    end

endmodule

// File: rtl/accum_regpath_chk.sv
module accum_regpath_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8,
    parameter int CTL_W  = 14
) (
    input logic              clk,
    input logic              rst,
    input logic [CTL_W-1:0]  ctl,
    input logic [DATA_W-1:0] ram_rdata,
    input logic [DATA_W-1:0] alu_result,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [DATA_W-1:0] ram_wdata,
    input logic              ram_we,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-ADDR_W-1:0] opcode,
    input logic [DATA_W-1:0] alu_a,
    input logic [DATA_W-1:0] alu_b
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (pc == '0 && ram_addr == '0 && ram_wdata == '0 &&
                 opcode == '0 && alu_a == '0 && alu_b == '0)); // R1
    AST_NO_WRITE_IN_RESET: assert property (@(posedge clk)
        rst |-> !ram_we); // R1
    AST_MAR_TAKES_PC: assert property (@(posedge clk) disable iff (rst)
        (ctl[8] && !ctl[3]) |=> ram_addr == $past(pc)); // R2
    AST_MAR_TAKES_OPERAND: assert property (@(posedge clk) disable iff (rst)
        ctl[3] |=> ram_addr == $past(ram_wdata[ADDR_W-1:0])); // R2
    AST_PC_STEPS: assert property (@(posedge clk) disable iff (rst)
        (ctl[9] && !ctl[4]) |=> pc == $past(pc) + ADDR_W'(1)); // R3
    AST_PC_JUMPS: assert property (@(posedge clk) disable iff (rst)
        ctl[4] |=> pc == $past(ram_wdata[ADDR_W-1:0])); // R3
    AST_MBR_FROM_RAM: assert property (@(posedge clk) disable iff (rst)
        ctl[0] |=> ram_wdata == $past(ram_rdata)); // R4
    AST_MBR_FROM_ACC: assert property (@(posedge clk) disable iff (rst)
        (ctl[2] && !ctl[0]) |=> ram_wdata == $past(alu_a)); // R4
    AST_IR_TAKES_HIGH_BYTE: assert property (@(posedge clk) disable iff (rst)
        ctl[5] |=> opcode == $past(ram_wdata[DATA_W-1 -: DATA_W-ADDR_W])); // R6
    AST_BR_TAKES_MBR: assert property (@(posedge clk) disable iff (rst)
        ctl[6] |=> alu_b == $past(ram_wdata)); // R7
    AST_ACC_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        ctl[13] |=> alu_a == '0); // R8
    AST_ACC_LOADS: assert property (@(posedge clk) disable iff (rst)
        (ctl[12] && !ctl[13]) |=> alu_a == $past(alu_result)); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ctl == '0) |=> ($stable(pc) && $stable(ram_addr) && $stable(ram_wdata) &&
                         $stable(opcode) && $stable(alu_a) && $stable(alu_b))); // R10

endmodule

bind accum_regpath accum_regpath_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CTL_W  (accum_pkg::CTL_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .ram_rdata  (ram_rdata),
    .alu_result (alu_result),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata),
    .ram_we     (ram_we),
    .pc         (pc),
    .opcode     (opcode),
    .alu_a      (alu_a),
    .alu_b      (alu_b)
);

// File: tb/tb_accum_regpath.sv
module tb_accum_regpath;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] ctl = '0;
    logic [15:0] ram_rdata = '0;
    logic [15:0] alu_result = '0;
    logic [7:0]  ram_addr;
    logic [15:0] ram_wdata;
    logic        ram_we;
    logic [7:0]  pc;
    logic [7:0]  opcode;
    logic [15:0] alu_a;
    logic [15:0] alu_b;
    logic        acc_neg;

    always #5 clk = ~clk;

    accum_regpath dut (
        .clk(clk), .rst(rst), .ctl(ctl), .ram_rdata(ram_rdata),
        .alu_result(alu_result), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_we(ram_we), .pc(pc), .opcode(opcode), .alu_a(alu_a),
        .alu_b(alu_b), .acc_neg(acc_neg)
    );

    typedef struct packed {
        logic [7:0]  mar;
        logic [15:0] mbr;
        logic        we;
        logic [7:0]  pcv;
        logic [7:0]  ir;
        logic [15:0] acc;
        logic [15:0] br;
        logic        neg;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;

    // reference model state
    logic [7:0]  m_mar = '0, m_pc = '0, m_ir = '0;
    logic [15:0] m_mbr = '0, m_br = '0, m_acc = '0;

    task automatic apply(input logic r, input logic [13:0] c,
                         input logic [15:0] rd, input logic [15:0] ay,
                         input string tag);
        logic [7:0]  n_mar, n_pc, n_ir;
        logic [15:0] n_mbr, n_br, n_acc;
        exp_t e;
        @(negedge clk);
        rst = r; ctl = c; ram_rdata = rd; alu_result = ay;
        n_mar = m_mar; n_pc = m_pc; n_ir = m_ir;
        n_mbr = m_mbr; n_br = m_br; n_acc = m_acc;
        if (r) begin
            n_mar = '0; n_pc = '0; n_ir = '0; n_mbr = '0; n_br = '0; n_acc = '0;
        end else begin
            if (c[3])      n_mar = m_mbr[7:0];
            else if (c[8]) n_mar = m_pc;
            if (c[4])      n_pc = m_mbr[7:0];
            else if (c[9]) n_pc = m_pc + 8'd1;
            if (c[0])      n_mbr = rd;
            else if (c[2]) n_mbr = m_acc;
            if (c[5])      n_ir = m_mbr[15:8];
            if (c[6])      n_br = m_mbr;
            if (c[13])     n_acc = '0;
            else if (c[12]) n_acc = ay;
        end
        m_mar = n_mar; m_pc = n_pc; m_ir = n_ir;
        m_mbr = n_mbr; m_br = n_br; m_acc = n_acc;
        e.mar = m_mar; e.mbr = m_mbr; e.we = c[1] & ~r; e.pcv = m_pc;
        e.ir = m_ir; e.acc = m_acc; e.br = m_br; e.neg = m_acc[15];
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: compares after each edge, while the applied vector is still held
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t  e;
                exp_t  a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a.mar = ram_addr; a.mbr = ram_wdata; a.we = ram_we; a.pcv = pc;
                a.ir = opcode; a.acc = alu_a; a.br = alu_b; a.neg = acc_neg;
                n_vec++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s: got mar=%h mbr=%h we=%b pc=%h ir=%h acc=%h br=%h neg=%b expected mar=%h mbr=%h we=%b pc=%h ir=%h acc=%h br=%h neg=%b",
                             t, a.mar, a.mbr, a.we, a.pcv, a.ir, a.acc, a.br, a.neg,
                             e.mar, e.mbr, e.we, e.pcv, e.ir, e.acc, e.br, e.neg);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        lf = 16'hACE1;
        apply(1, 14'h0000, 16'h0000, 16'h0000, "R1 reset");
        apply(1, 14'h3FFF, 16'hFFFF, 16'hFFFF, "R1 reset with all controls");
        // fetch-like: read word, decode opcode, operand to address
        apply(0, 14'h0001, 16'h0A23, 16'h0000, "R4 mbr from ram");
        apply(0, 14'h0020, 16'h5555, 16'h0000, "R6 ir from high byte");
        apply(0, 14'h0008, 16'h0000, 16'h0000, "R2 mar from operand");
        apply(0, 14'h0010, 16'h0000, 16'h0000, "R3 pc jump");
        apply(0, 14'h0200, 16'h0000, 16'h0000, "R3 pc step");
        apply(0, 14'h0100, 16'h0000, 16'h0000, "R2 mar from pc");
        apply(0, 14'h0001, 16'h80FF, 16'h0000, "R4 mbr reload");
        apply(0, 14'h0210, 16'h0000, 16'h0000, "R3 jump beats step");
        apply(0, 14'h0200, 16'h0000, 16'h0000, "R3 wrap ff to 00");
        apply(0, 14'h0108, 16'h0000, 16'h0000, "R2 operand beats pc");
        apply(0, 14'h0040, 16'h0000, 16'h0000, "R7 br from mbr");
        apply(0, 14'h1000, 16'h0000, 16'h8001, "R8 acc load R9 negative");
        apply(0, 14'h0004, 16'h0000, 16'h0000, "R4 mbr from acc");
        apply(0, 14'h0002, 16'h0000, 16'h0000, "R5 write strobe");
        apply(0, 14'h0005, 16'h1234, 16'h0000, "R4 ram beats acc");
        apply(0, 14'h3000, 16'h0000, 16'h7FFF, "R8 clear beats load");
        apply(0, 14'h1000, 16'h0000, 16'h7FFF, "R9 non-negative");
        apply(0, 14'h0C80, 16'hFFFF, 16'hFFFF, "R10 bits 7 10 11 ignored");
        apply(0, 14'h0000, 16'hFFFF, 16'h0000, "R10 idle hold");
        for (int i = 0; i < 80; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            apply(0, lf[13:0], {lf[7:0], lf[15:8]}, lf ^ 16'h5A5A, "R10 mixed transfers");
        end
        apply(1, 14'h0000, 16'h0000, 16'h0000, "R1 reset mid-run");
        apply(0, 14'h0000, 16'h0000, 16'h0000, "R1 after reset");
        @(negedge clk);
        ctl = '0;
        @(posedge clk);
        #3;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule